// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Adapter

This block sits between the DMA request side of a 16-bit network controller and a byte-addressed memory master. The controller asks for a transfer by giving a low address, a byte length, a direction and a flag that bypasses swapping. The adapter ORs the low address with a stored upper-address register to form the full memory address. It then moves the data one 16-bit halfword per memory beat, with a pair of byte enables.

With swapping active, the adapter first clears bit 0 of both the address and the length. It then exchanges the two bytes of every halfword in both directions. Memory writes in this mode are cut into bursts of at most 64 bytes, and a burst-end marker flags the last beat of each one. With the bypass flag set, the exact address and length are used and the data passes through unchanged.

Write data comes from the controller's `srcData` and is consumed on `srcTake`. Read data reaches the controller on `dstData` when `dstValid` is high. A one-cycle `done` pulse closes every request.

Top module: `hswap_dma`

## Requirements
- R1: The memory address of the first beat is the request address ORed with the upper-address register, which is loaded through `upperWe`/`upperData`; later beats advance from that address.
- R2: With `reqBypass` = 1, address and length are used unchanged and data is not altered. A beat at an odd byte address carries only the high lane (`memBe` = 2'b10). A single trailing byte at an even address carries only the low lane (`memBe` = 2'b01). Every other beat is 2'b11. `memAddr` always has bit 0 cleared, lane 0 is bits 7:0 (even byte) and lane 1 is bits 15:8 (odd byte).
- R3: With `reqBypass` = 0, bit 0 of the combined address and bit 0 of the length are cleared before the transfer, and every beat has `memBe` = 2'b11.
- R4: With `reqBypass` = 0 and a write (`reqWrite` = 1), `memWdata` is `srcData` with its two bytes exchanged.
- R5: With `reqBypass` = 0 and a read, `dstData` is `memRdata` with its two bytes exchanged.
- R6: In a swapping write, `memLast` is high on the beat that completes each 64 bytes of the transfer and on the final beat.
- R7: In reads and in bypass writes, `memLast` is high only on the final beat.
- R8: A request whose effective length is zero raises `done` in the next cycle and produces no memory beat.
- R9: `done` is high for exactly the one cycle after the final beat's handshake and is low otherwise.
- R10: A beat is presented on `memValid` and completes when `memReady` is high. While stalled, address, enables, data and burst marker hold. `srcTake` and `dstValid` are high only on a completed write or read beat.
- R11: `reqReady` is high only when no transfer is in progress, and a `reqValid` raised during a transfer is ignored (no extra beats, no extra `done`).
- R12: After reset the adapter is idle: `reqReady` = 1, `memValid` = 0, `done` = 0, and the upper register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upperWe | input | 1 | Load strobe for the upper-address register |
| upperData | input | AW | Value for the upper-address register |
| reqValid | input | 1 | Transfer request present |
| reqReady | output | 1 | Adapter idle, request will be taken |
| reqAddr | input | AW | Low byte address of the request |
| reqLen | input | LW | Length in bytes |
| reqWrite | input | 1 | 1 = write to memory, 0 = read from memory |
| reqBypass | input | 1 | 1 = no swapping and no forced alignment |
| done | output | 1 | One-cycle completion pulse |
| srcData | input | 16 | Write halfword from the controller |
| srcTake | output | 1 | `srcData` consumed this cycle |
| dstValid | output | 1 | `dstData` valid this cycle |
| dstData | output | 16 | Read halfword to the controller |
| memValid | output | 1 | Memory beat request |
| memReady | input | 1 | Memory accepts the beat |
| memWrite | output | 1 | Beat direction, 1 = write |
| memAddr | output | AW | Halfword-aligned byte address |
| memBe | output | 2 | Byte enables, bit 0 = even byte |
| memWdata | output | 16 | Write data to memory |
| memRdata | input | 16 | Read data from memory, valid with the handshake |
| memLast | output | 1 | Last beat of a burst |

## Verification
The assertions assume that memory returns `memRdata` in the same cycle as the handshake. They also assume that `srcData` holds its value until `srcTake`, and that no request fields change while a transfer runs. The bench drives `srcData` from a register that only moves on `srcTake`. It derives `memRdata` combinationally from `memAddr`. It changes request fields only while idle, except for a deliberate stream of junk requests during one busy transfer, which the adapter must ignore. `memReady` alternates between always-high and a periodic stall pattern, so held beats are covered.

// File: rtl/hswap_pkg.sv
package hswap_pkg;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic       load;
    logic       step;
    logic [1:0] stepBytes;
    logic       swap;
    logic       active;
  } hsStrb_t;

  function automatic logic [HALF_W-1:0] swapHalf(input logic [HALF_W-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/hswap_datapath.sv
module hswap_datapath
  import hswap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upperWe,
  input  logic [AW-1:0]     upperData,
  input  logic [AW-1:0]     reqAddr,
  input  logic              reqBypass,
  input  hsStrb_t           strb,
  input  logic [HALF_W-1:0] srcData,
  input  logic [HALF_W-1:0] memRdata,
  output logic [AW-1:0]     memAddr,
  output logic              addrOdd,
  output logic [HALF_W-1:0] memWdata,
  output logic [HALF_W-1:0] dstData
);
  logic [AW-1:0] upperReg;
  logic [AW-1:0] curAddr;
  logic [AW-1:0] joined;
  logic [AW-1:0] startAddr;

  always_comb begin
    joined    = reqAddr | upperReg;
    startAddr = reqBypass ? joined : {joined[AW-1:1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperReg <= '0;
      curAddr  <= '0;
    end else begin
      if (upperWe) upperReg <= upperData;
      if (strb.load) curAddr <= startAddr;
      else if (strb.step) curAddr <= curAddr + AW'(strb.stepBytes);
    end
  end

  assign memAddr = {curAddr[AW-1:1], 1'b0};
  assign addrOdd = curAddr[0];
  assign memWdata = strb.swap ? swapHalf(srcData)  : srcData;
  assign dstData  = strb.swap ? swapHalf(memRdata) : memRdata;

  // R3
  swap_addr_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.active && strb.swap |-> !addrOdd);

  // R10
  stall_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.active && !strb.step && !strb.load |=> $stable(curAddr));
endmodule

// File: rtl/hswap_ctrl.sv
module hswap_ctrl
  import hswap_pkg::*;
#(
  parameter int LW          = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [LW-1:0] reqLen,
  input  logic          reqWrite,
  input  logic          reqBypass,
  output logic          reqReady,
  input  logic          addrOdd,
  input  logic          memReady,
  output logic          memValid,
  output logic          memWrite,
  output logic [1:0]    memBe,
  output logic          memLast,
  output logic          srcTake,
  output logic          dstValid,
  output logic          done,
  output hsStrb_t       strb
);
  localparam int CW = $clog2(CHUNK_BYTES) + 1;

  logic          busy;
  logic          bypassMode;
  logic          writeMode;
  logic [LW-1:0] remaining;
  logic [CW-1:0] chunkCnt;

  logic          accept;
  logic [LW-1:0] effLen;
  logic          oneLeft;
  logic [1:0]    beatBytes;
  logic          beat;
  logic          finalBeat;
  logic [CW-1:0] chunkNext;
  logic          chunkMode;
  logic          chunkEnd;

  always_comb begin
    accept    = reqValid && !busy;
    effLen    = reqBypass ? reqLen : {reqLen[LW-1:1], 1'b0};
    oneLeft   = (remaining == LW'(1));
    beatBytes = (addrOdd || oneLeft) ? 2'd1 : 2'd2;
    memBe     = addrOdd ? 2'b10 : (oneLeft ? 2'b01 : 2'b11);
    beat      = busy && memReady;
    finalBeat = (remaining == LW'(beatBytes));
    chunkMode = !bypassMode && writeMode;
    chunkNext = chunkCnt + CW'(beatBytes);
    chunkEnd  = chunkMode && (chunkNext == CW'(CHUNK_BYTES));
    memLast   = busy && (finalBeat || chunkEnd);
    strb.load      = accept;
    strb.step      = beat;
    strb.stepBytes = beatBytes;
    strb.swap      = !bypassMode;
    strb.active    = busy;
  end

  assign reqReady = !busy;
  assign memValid = busy;
  assign memWrite = writeMode;
  assign srcTake  = beat && writeMode;
  assign dstValid = beat && !writeMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      bypassMode <= 1'b0;
      writeMode  <= 1'b0;
      remaining  <= '0;
      chunkCnt   <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        bypassMode <= reqBypass;
        writeMode  <= reqWrite;
        remaining  <= effLen;
        chunkCnt   <= '0;
        if (effLen == '0) done <= 1'b1;
        else busy <= 1'b1;
      end else if (beat) begin
        remaining <= remaining - LW'(beatBytes);
        if (chunkEnd) chunkCnt <= '0;
        else if (chunkMode) chunkCnt <= chunkNext;
        if (finalBeat) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10
  stall_beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memBe) && $stable(memLast));

  // R3
  swap_full_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !bypassMode |-> memBe == 2'b11);

  // R9
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R6
  chunk_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    chunkCnt < CW'(CHUNK_BYTES));

  // R11
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memLast |=> memValid);
endmodule

// File: rtl/hswap_dma.sv
module hswap_dma
  import hswap_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          upperWe,
  input  logic [AW-1:0] upperData,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqAddr,
  input  logic [LW-1:0] reqLen,
  input  logic          reqWrite,
  input  logic          reqBypass,
  output logic          done,
  input  logic [15:0]   srcData,
  output logic          srcTake,
  output logic          dstValid,
  output logic [15:0]   dstData,
  output logic          memValid,
  input  logic          memReady,
  output logic          memWrite,
  output logic [AW-1:0] memAddr,
  output logic [1:0]    memBe,
  output logic [15:0]   memWdata,
  input  logic [15:0]   memRdata,
  output logic          memLast
);
  hsStrb_t strb;
  logic    addrOdd;

  hswap_ctrl #(.LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLen(reqLen), .reqWrite(reqWrite),
    .reqBypass(reqBypass), .reqReady(reqReady),
    .addrOdd(addrOdd), .memReady(memReady),
    .memValid(memValid), .memWrite(memWrite), .memBe(memBe),
    .memLast(memLast), .srcTake(srcTake), .dstValid(dstValid),
    .done(done), .strb(strb)
  );

  hswap_datapath #(.AW(AW)) i_data (
    .clk(clk), .rstN(rstN),
    .upperWe(upperWe), .upperData(upperData),
    .reqAddr(reqAddr), .reqBypass(reqBypass), .strb(strb),
    .srcData(srcData), .memRdata(memRdata),
    .memAddr(memAddr), .addrOdd(addrOdd),
    .memWdata(memWdata), .dstData(dstData)
  );
endmodule

// File: tb/test_hswap_dma.sv
`timescale 1ns/1ps
module test_hswap_dma;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upperWe = 1'b0;
  logic [31:0] upperData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic        reqWrite = 1'b0;
  logic        reqBypass = 1'b0;
  logic        done;
  logic [15:0] srcWord = 16'h1A2B;
  logic        srcTake;
  logic        dstValid;
  logic [15:0] dstData;
  logic        memValid;
  logic        memReady = 1'b1;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [1:0]  memBe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        memLast;

  always #10 clk = ~clk;

  hswap_dma i_hswap_dma (
    .clk(clk), .rstN(rstN), .upperWe(upperWe), .upperData(upperData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWrite(reqWrite), .reqBypass(reqBypass),
    .done(done), .srcData(srcWord), .srcTake(srcTake),
    .dstValid(dstValid), .dstData(dstData), .memValid(memValid),
    .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .memLast(memLast)
  );

  function automatic logic [7:0] byteAt(input logic [31:0] a);
    return a[7:0] ^ 8'hC3 ^ {6'd0, a[9:8]};
  endfunction
  function automatic logic [15:0] memWord(input logic [31:0] a);
    return {byteAt(a + 32'd1), byteAt(a)};
  endfunction
  assign memRdata = memWord(memAddr);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  bit stallMode = 0;
  bit pendDone = 0;
  bit zeroPend = 0;
  bit curSwap = 0;
  bit curWrite = 0;
  string addrTag = "R3";
  logic [31:0] upperVal = '0;
  logic [31:0] qAddr[$];
  logic [1:0]  qBe[$];
  bit          qLast[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    memReady <= stallMode ? ((cyc % 5) != 2 && (cyc % 7) != 4) : 1'b1;
    if (srcTake) srcWord <= srcWord + 16'h1357;
  end

  always @(negedge clk) if (started) begin
    logic [15:0] raw;
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R9", "watchdog expired", cyc, 150000);
      finish();
    end
    chk(done == (pendDone || zeroPend), zeroPend ? "R8" : "R9", "done",
        {31'd0, done}, {31'd0, pendDone || zeroPend});
    pendDone = 0;
    zeroPend = 0;
    if (memValid) begin
      if (qAddr.size() == 0) begin
        chk(0, "R11", "unexpected beat", memAddr, 0);
      end else begin
        chk(memAddr == qAddr[0], addrTag, "memAddr", memAddr, qAddr[0]);
        chk(memBe == qBe[0], curSwap ? "R3" : "R2", "memBe", {30'd0, memBe}, {30'd0, qBe[0]});
        chk(memLast == qLast[0], (curSwap && curWrite) ? "R6" : "R7", "memLast",
            {31'd0, memLast}, {31'd0, qLast[0]});
        chk(memWrite == curWrite, "R10", "memWrite", {31'd0, memWrite}, {31'd0, curWrite});
        if (curWrite) begin
          raw = curSwap ? {srcWord[7:0], srcWord[15:8]} : srcWord;
          chk(memWdata == raw, curSwap ? "R4" : "R2", "memWdata", {16'd0, memWdata}, {16'd0, raw});
        end else if (memReady) begin
          raw = memWord(qAddr[0]);
          if (curSwap) raw = {raw[7:0], raw[15:8]};
          chk(dstData == raw, curSwap ? "R5" : "R2", "dstData", {16'd0, dstData}, {16'd0, raw});
        end
        chk(srcTake == (memReady && curWrite) && dstValid == (memReady && !curWrite),
            "R10", "take/valid", {30'd0, srcTake, dstValid},
            {30'd0, memReady && curWrite, memReady && !curWrite});
        if (memReady) begin
          void'(qAddr.pop_front());
          void'(qBe.pop_front());
          void'(qLast.pop_front());
          if (qAddr.size() == 0) pendDone = 1;
        end
      end
    end else begin
      chk(!srcTake && !dstValid, "R10", "take/valid while idle",
          {30'd0, srcTake, dstValid}, 0);
    end
  end

  task automatic plan(input logic [31:0] a0, input int len, input bit wr, input bit byp);
    logic [31:0] a;
    logic [1:0] be;
    int l, n, ch;
    a = a0 | upperVal;
    l = len;
    if (!byp) begin
      a[0] = 1'b0;
      l = l & ~1;
    end
    ch = 0;
    while (l > 0) begin
      if (a[0]) begin be = 2'b10; n = 1; end
      else if (l == 1) begin be = 2'b01; n = 1; end
      else begin be = 2'b11; n = 2; end
      qAddr.push_back({a[31:1], 1'b0});
      qBe.push_back(be);
      qLast.push_back((l == n) || (!byp && wr && (ch + n == 64)));
      ch = (ch + n == 64) ? 0 : ch + n;
      a = a + 32'(n);
      l = l - n;
    end
  endtask

  task automatic waitIdle();
    do begin
      @(negedge clk);
      #2;
    end while (qAddr.size() != 0 || !reqReady);
    @(negedge clk);
    #2;
  endtask

  task automatic setUpper(input logic [31:0] v);
    waitIdle();
    upperWe = 1'b1;
    upperData = v;
    @(posedge clk);
    #1;
    upperWe = 1'b0;
    upperVal = v;
  endtask

  task automatic issue(input logic [31:0] a, input int len, input bit wr, input bit byp);
    waitIdle();
    reqAddr = a;
    reqLen = 16'(len);
    reqWrite = wr;
    reqBypass = byp;
    curSwap = !byp;
    curWrite = wr;
    plan(a, len, wr, byp);
    reqValid = 1'b1;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    if ((byp ? len : (len & ~1)) == 0) zeroPend = 1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    // R12: idle after reset
    chk(reqReady == 1'b1 && memValid == 1'b0 && done == 1'b0, "R12", "reset state",
        {29'd0, reqReady, memValid, done}, 32'h4);
    started = 1;

    addrTag = "R3";
    issue(32'h11, 9, 1, 0);        // R3 R4: odd address and length forced even
    issue(32'h40, 150, 1, 0);      // R6: chunk markers at 64 and 128
    issue(32'h80, 6, 0, 0);        // R5: swapped reads
    issue(32'h100, 130, 0, 0);     // R7: no chunk markers on reads
    addrTag = "R2";
    issue(32'h21, 6, 1, 1);        // R2: odd start, lone trailing byte
    issue(32'h30, 5, 0, 1);        // R2: bypass read
    issue(32'h60, 100, 1, 1);      // R7: bypass write single burst
    addrTag = "R3";
    issue(32'h70, 1, 1, 0);        // R8: length forced to zero
    issue(32'h70, 0, 0, 1);        // R8: zero bypass length

    stallMode = 1;
    issue(32'h13, 140, 1, 0);      // R10: stalls in swapping write
    addrTag = "R2";
    issue(32'h45, 11, 0, 1);       // R10: stalls in bypass read

    setUpper(32'h0000_0200);
    addrTag = "R1";
    issue(32'h11, 4, 1, 1);        // R1: exact OR in bypass
    setUpper(32'h0000_0301);
    issue(32'h10, 4, 0, 0);        // R1 R3: ORed bit 0 cleared in swap mode

    // R11: junk requests while busy are ignored
    addrTag = "R3";
    issue(32'h90, 20, 1, 0);
    forever begin
      @(negedge clk);
      #2;
      if (reqReady) break;
      reqValid = 1'b1;
      reqAddr = 32'hFFF0;
      reqLen = 16'd40;
      reqWrite = 1'b0;
      reqBypass = 1'b1;
    end
    reqValid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #2;
      chk(reqReady && !memValid, "R11", "stays idle after ignored requests",
          {30'd0, reqReady, memValid}, 32'h2);
    end

    stallMode = 0;
    waitIdle();
    chk(qAddr.size() == 0, "R9", "all beats seen", qAddr.size(), 0);
    finish();
  end
endmodule